// File: doc/BRIEF.md
# Low-Side Channel Fault Latch Controller

This block holds the gate-enable and diagnostic flag logic for one switching channel of a quad low-side power driver. A chip-level wrapper instantiates it once per channel. It takes a channel command level, a thermal-overload detect and an open-load detect. All three are synchronised to the system clock inside the block. From them it produces the gate enable for the output transistor, two sticky status flags and a one-cycle pulse for the shared interrupt logic. The two flags feed the diagnostic shift register.

The thermal flag and the shutdown latch behind it are released by a rising command edge. The open-load flag is released by a falling command edge, and it is only evaluated while the channel is commanded off. A thermal event turns the output off whatever the command level. An open load never does. An active-low reset clears all state and disables the output. A power-good input holds the output off while it is low, and leaves the flags alone.

Top module: `lsd_chan_guard`

## Requirements
- R1: While `rst_n` is low, `gate_en`, `hot_flag`, `open_flag` and `fault_pulse` are all 0. After release, the channel starts from that cleared state.
- R2: While `pwr_ok` is 0, `gate_en` is 0 in the same cycle. Power-good going low changes neither flag.
- R3: With no shutdown latched and `pwr_ok` high, `gate_en` follows `cmd_in` after the SYNC_STAGES synchroniser delay.
- R4: A high `hot_det` sets `hot_flag` and the shutdown latch, driving `gate_en` to 0, whether `cmd_in` is 1 or 0.
- R5: `hot_flag` and the shutdown hold until a rising edge of the synchronised command seen while `hot_det` is low. A rising edge while `hot_det` is still high leaves both set. A falling edge does not clear them.
- R6: `open_det` sets `open_flag` only while the synchronised command is 0. While the command is 1 it is ignored.
- R7: `open_flag` clears on a falling edge of the synchronised command. If `open_det` is still high, the flag sets again in the following cycle of that off period and raises a new pulse. A rising edge does not clear it.
- R8: `open_flag` never forces `gate_en` to 0. With the flag set and `cmd_in` high, the output is on.
- R9: `fault_pulse` is 1 for exactly the cycle in which `hot_flag` or `open_flag` changes from 0 to 1, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pwr_ok | input | 1 | Supply above power-on threshold; low holds output off |
| cmd_in | input | 1 | Channel command level, 1 = output on |
| hot_det | input | 1 | Thermal-overload detect from the sensing front end |
| open_det | input | 1 | Open-load detect from the sensing front end |
| gate_en | output | 1 | Gate drive enable for the output transistor |
| hot_flag | output | 1 | Sticky thermal-overload status bit |
| open_flag | output | 1 | Sticky open-load status bit |
| fault_pulse | output | 1 | One-cycle pulse when either flag newly sets |

## Verification
On every cycle, the assertions check these properties:
- the output is off whenever power-good is low or the thermal flag is set;
- each flag falls only one cycle after the matching command edge;
- the open-load flag rises only after an off-command cycle;
- the pulse coincides exactly with a flag rising.

Some behaviour can only be shown by the bench's scenarios:
- re-triggering within an off period;
- a rising edge while overheating, which does not release the latch;
- an open-load detect ignored while the channel is on;
- the cleared state after reset release.

Those rest on chosen input sequences and pulse counts over a window.

// File: rtl/lsd_guard_pkg.sv
package lsd_guard_pkg;

   // Synchronised view of the three asynchronous channel inputs
   typedef struct packed {
      logic cmd;
      logic hot;
      logic open;
   } chan_in_t;

   localparam int unsigned CHAN_IN_W       = $bits(chan_in_t);
   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/lsd_guard_sync.sv
module lsd_guard_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stage [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q = stage[LAST];

endmodule

// File: rtl/lsd_guard_edge.sv
module lsd_guard_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/lsd_guard_flags.sv
module lsd_guard_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_s,
   input  logic hot_s,
   input  logic open_s,
   input  logic cmd_rise,
   input  logic cmd_fall,
   output logic shut_q,
   output logic hot_flag,
   output logic open_flag,
   output logic fault_pulse
);

   logic shut_nxt;
   logic hot_nxt;
   logic open_nxt;
   logic new_evt;

   // Thermal side: set has priority so a persisting overload re-latches
   always_comb begin
      shut_nxt = shut_q;
      hot_nxt  = hot_flag;
      if (hot_s) begin
         shut_nxt = 1'b1;
         hot_nxt  = 1'b1;
      end else if (cmd_rise) begin
         shut_nxt = 1'b0;
         hot_nxt  = 1'b0;
      end
   end

   // Open-load side: clear wins on the falling edge, detection resumes after
   always_comb begin
      open_nxt = open_flag;
      if (cmd_fall)              open_nxt = 1'b0;
      else if (open_s && !cmd_s) open_nxt = 1'b1;
   end

   assign new_evt = (hot_nxt & ~hot_flag) | (open_nxt & ~open_flag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shut_q      <= 1'b0;
         hot_flag    <= 1'b0;
         open_flag   <= 1'b0;
         fault_pulse <= 1'b0;
      end else begin
         shut_q      <= shut_nxt;
         hot_flag    <= hot_nxt;
         open_flag   <= open_nxt;
         fault_pulse <= new_evt;
      end
   end

endmodule

// File: rtl/lsd_chan_guard.sv
module lsd_chan_guard #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok,
   input  logic cmd_in,
   input  logic hot_det,
   input  logic open_det,
   output logic gate_en,
   output logic hot_flag,
   output logic open_flag,
   output logic fault_pulse
);
   import lsd_guard_pkg::*;

   generate
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("lsd_chan_guard: SYNC_STAGES must be at least 2");
      end
   endgenerate

   chan_in_t raw_in;
   chan_in_t sync_in;
   logic     cmd_s;
   logic     cmd_rise;
   logic     cmd_fall;
   logic     shut_q;

   assign raw_in = '{cmd: cmd_in, hot: hot_det, open: open_det};

   lsd_guard_sync #(
      .WIDTH  (CHAN_IN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_in)
   );

   assign cmd_s = sync_in.cmd;

   lsd_guard_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (cmd_s),
      .rise  (cmd_rise),
      .fall  (cmd_fall)
   );

   lsd_guard_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_s       (cmd_s),
      .hot_s       (sync_in.hot),
      .open_s      (sync_in.open),
      .cmd_rise    (cmd_rise),
      .cmd_fall    (cmd_fall),
      .shut_q      (shut_q),
      .hot_flag    (hot_flag),
      .open_flag   (open_flag),
      .fault_pulse (fault_pulse)
   );

   assign gate_en = cmd_s & ~shut_q & rst_n & pwr_ok;

endmodule

// File: rtl/lsd_chan_guard_chk.sv
module lsd_chan_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_ok,
   input logic cmd_s,
   input logic cmd_rise,
   input logic cmd_fall,
   input logic gate_en,
   input logic hot_flag,
   input logic open_flag,
   input logic fault_pulse
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (!gate_en && !hot_flag && !open_flag && !fault_pulse));

   // R2
   pwr_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |-> !gate_en);

   // R4
   hot_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hot_flag |-> !gate_en);

   // R5
   hot_release_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hot_flag) |-> $past(cmd_rise));

   // R6
   open_set_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_flag) |-> $past(!cmd_s));

   // R7
   open_release_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_flag) |-> $past(cmd_fall));

   // R9
   pulse_on_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hot_flag) || $rose(open_flag)) |-> fault_pulse);

   // R9
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> ($rose(hot_flag) || $rose(open_flag)));

endmodule

bind lsd_chan_guard lsd_chan_guard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_ok      (pwr_ok),
   .cmd_s       (cmd_s),
   .cmd_rise    (cmd_rise),
   .cmd_fall    (cmd_fall),
   .gate_en     (gate_en),
   .hot_flag    (hot_flag),
   .open_flag   (open_flag),
   .fault_pulse (fault_pulse)
);

// File: tb/lsd_chan_guard_bench.sv
module lsd_chan_guard_bench;

   // vector: cmd hot open pwr | gate hflag oflag | pulses[1:0] | req[3:0]
   typedef logic [12:0] vec_t;
   localparam int NVEC = 24;
   localparam int STEP_CYC = 8;

   localparam vec_t VECS [NVEC] = '{
      {4'b1001, 3'b100, 2'd0, 4'd3},   // R3 on
      {4'b1101, 3'b010, 2'd1, 4'd4},   // R4 overheat while on
      {4'b1001, 3'b010, 2'd0, 4'd5},   // R5 held after cooling
      {4'b0001, 3'b010, 2'd0, 4'd5},   // R5 fall does not clear
      {4'b1001, 3'b100, 2'd0, 4'd5},   // R5 rise releases
      {4'b1011, 3'b100, 2'd0, 4'd6},   // R6 open ignored while on
      {4'b0011, 3'b001, 2'd1, 4'd6},   // R6 open seen while off
      {4'b1011, 3'b101, 2'd0, 4'd8},   // R8 open does not shut output
      {4'b0011, 3'b001, 2'd1, 4'd7},   // R7 clear then re-set
      {4'b0001, 3'b001, 2'd0, 4'd7},   // R7 sticky
      {4'b1001, 3'b101, 2'd0, 4'd7},   // R7 rise does not clear
      {4'b0001, 3'b000, 2'd0, 4'd7},   // R7 fall clears
      {4'b1101, 3'b010, 2'd1, 4'd4},   // R4
      {4'b0101, 3'b010, 2'd0, 4'd5},   // R5
      {4'b1101, 3'b010, 2'd0, 4'd5},   // R5 rise while hot keeps latch
      {4'b1001, 3'b010, 2'd0, 4'd5},   // R5
      {4'b0001, 3'b010, 2'd0, 4'd5},   // R5
      {4'b1001, 3'b100, 2'd0, 4'd5},   // R5
      {4'b1000, 3'b000, 2'd0, 4'd2},   // R2 power low
      {4'b1001, 3'b100, 2'd0, 4'd2},   // R2 power back
      {4'b0101, 3'b010, 2'd1, 4'd4},   // R4 overheat while off
      {4'b0001, 3'b010, 2'd0, 4'd5},   // R5
      {4'b0000, 3'b010, 2'd0, 4'd2},   // R2 flags kept with power low
      {4'b1001, 3'b100, 2'd0, 4'd5}    // R5
   };

   logic clk = 1'b0;
   logic rst_n, pwr_ok, cmd_in, hot_det, open_det;
   logic gate_en, hot_flag, open_flag, fault_pulse;

   int checks = 0;
   int errors = 0;
   int pulse_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lsd_chan_guard u_lsd_chan_guard (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cmd_in(cmd_in),
      .hot_det(hot_det), .open_det(open_det), .gate_en(gate_en),
      .hot_flag(hot_flag), .open_flag(open_flag), .fault_pulse(fault_pulse)
   );

   always @(posedge clk) if (fault_pulse) pulse_cnt <= pulse_cnt + 1;

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {gate,hot,open,pulses} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finished");
         report();
      end
   end

   initial begin
      rst_n = 1'b0; pwr_ok = 1'b1; cmd_in = 1'b0; hot_det = 1'b0; open_det = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {gate_en, hot_flag, open_flag, fault_pulse, 1'b0}, 5'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         vec_t v = VECS[i];
         cmd_in = v[12]; hot_det = v[11]; open_det = v[10]; pwr_ok = v[9];
         pulse_cnt = 0;
         repeat (STEP_CYC) @(negedge clk);
         check($sformatf("R%0d step %0d", v[3:0], i),
               {gate_en, hot_flag, open_flag, pulse_cnt[1:0]}, {v[8:6], v[5:4]});
      end

      // R1 reset mid-operation clears set flags at once
      cmd_in = 1'b0; hot_det = 1'b1; open_det = 1'b1;
      repeat (STEP_CYC) @(negedge clk);
      check("R1 pre", {gate_en, hot_flag, open_flag, 2'b00}, 5'b01100);
      rst_n = 1'b0;
      #1;
      check("R1 async", {gate_en, hot_flag, open_flag, fault_pulse, 1'b0}, 5'b0);
      cmd_in = 1'b1; hot_det = 1'b0; open_det = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 held", {gate_en, hot_flag, open_flag, fault_pulse, 1'b0}, 5'b0);
      rst_n = 1'b1;
      pulse_cnt = 0;
      repeat (STEP_CYC) @(negedge clk);
      check("R1 release", {gate_en, hot_flag, open_flag, pulse_cnt[1:0]}, 5'b10000);

      // R3 latency: gate still low one cycle after command, high after two
      cmd_in = 1'b0;
      repeat (STEP_CYC) @(negedge clk);
      cmd_in = 1'b1;
      @(negedge clk);
      check("R3 lat1", {gate_en, 4'b0}, 5'b00000);
      @(negedge clk);
      check("R3 lat2", {gate_en, 4'b0}, 5'b10000);

      done = 1'b1;
      report();
   end

endmodule